// File: doc/BRIEF.md
# Triggered One-Shot Waveform Player

This block holds a constant waveform table and plays it out once each time it receives a trigger. Playback begins at entry 0 and ends after entry DEPTH-1. Speed is set by a fractional rate accumulator. On every enabled cycle of a pass, the accumulator adds RATE_STEP modulo RATE_LIMIT. It raises a step event on the cycles where the sum reaches RATE_LIMIT. Each step event reads one table entry into a registered output. Over a pass, the playback time therefore stretches by RATE_LIMIT/RATE_STEP compared with one entry per cycle.

A small controller has two states. In ST_IDLE the block waits. The transition IDLE_TO_PLAY is taken when a trigger is seen while enable is high. That transition also clears the accumulator and the table address. In ST_PLAY the accumulator and address walker run. The transition PLAY_TO_IDLE is taken on the step event that reads the last entry. The address then returns to 0. The busy output shows that the block is in ST_PLAY. The last sample is held until the next pass.

Top module: `wave_oneshot_player`

## Requirements
- R1: Reset is synchronous and active high, and it takes priority over enable and trigger. After a clock edge with `rst` high, `busy` is 0 and `sample` is 0.
- R2: In idle, a clock edge with `en` and `trig` both high starts a pass. `busy` is 1 after that edge, the pass starts at table entry 0, and the rate accumulator starts from 0.
- R3: During a pass, each clock edge with `en` high advances the rate accumulator by RATE_STEP modulo RATE_LIMIT, where 1 <= RATE_STEP <= RATE_LIMIT. A step event happens when the accumulator value is at least RATE_LIMIT-RATE_STEP. After k enabled edges of a pass, min(floor(k*RATE_STEP/RATE_LIMIT), DEPTH) entries have been emitted.
- R4: On each step event, the current table entry is registered onto `sample` at that edge. Entries appear in the order 0, 1, ..., DEPTH-1, and before the first step event `sample` keeps its previous value.
- R5: Table entry i holds (TBL_MUL*i + TBL_ADD) mod 2^DW. The defaults are 29 and 7, with DW = 8.
- R6: A pass ends on the edge that emits entry DEPTH-1, and `busy` is 0 after that edge. A pass therefore lasts ceil(DEPTH*RATE_LIMIT/RATE_STEP) enabled edges.
- R7: A trigger during a pass is ignored. The pass continues and ends on the same enabled edge it would have ended on without the trigger.
- R8: While `en` is low, nothing changes. `sample`, `busy` and the pass progress hold their values, and a trigger has no effect.
- R9: In idle, `sample` holds the last emitted value until a new pass emits an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the whole block |
| trig | input | 1 | Starts a pass when idle |
| sample | output | DW | Registered table output |
| busy | output | 1 | High while a pass is in progress |

## Verification
The hardest state to reach is an interaction with the fractional cadence in the middle of a pass: enable dropping, or a second trigger arriving, between step events. The stimulus reaches it by counting enabled edges from the trigger. It then removes enable, or pulses trigger, at a chosen count. The expected end edge, ceil(DEPTH*L/S) enabled edges after the start, is fixed. So any disturbance of the accumulator or the address shows up either as a shifted busy fall or as a wrong sample at a particular count.

// File: rtl/player_pkg.sv
package player_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

    // Table generator: entry i of the stored waveform before truncation to DW bits.
    function automatic int table_entry(input int idx, input int mul, input int add);
        return mul * idx + add;
    endfunction

endpackage

// File: rtl/rate_accum.sv
module rate_accum #(
    parameter int LIMIT = 5,
    parameter int STEP  = 3,
    localparam int RW   = $clog2(2 * LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic          step,
    output logic [RW-1:0] acc
);

    localparam logic [RW-1:0] GAP = RW'(LIMIT - STEP);
    localparam logic [RW-1:0] INC = RW'(STEP);

    logic [RW-1:0] acc_q;

    // Step event whenever adding STEP would reach or pass LIMIT.
    assign step = (acc_q >= GAP);
    assign acc  = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (adv) begin
            if (step) begin
                acc_q <= acc_q - GAP;
            end else begin
                acc_q <= acc_q + INC;
            end
        end
    end

endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic          at_last,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    assign at_last = (addr_q == LAST);
    assign addr    = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (adv) begin
            if (at_last) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_q + AW'(1);
            end
        end
    end

endmodule

// File: rtl/wave_table.sv
module wave_table #(
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter int TBL_MUL = 29,
    parameter int TBL_ADD = 7,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    logic [DW-1:0] rom [DEPTH];

    // Constant contents computed at elaboration.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
        assign rom[gi] = DW'(player_pkg::table_entry(gi, TBL_MUL, TBL_ADD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (ld) begin
            data <= rom[addr];
        end
    end

endmodule

// File: rtl/play_ctrl.sv
module play_ctrl
    import player_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    input  logic step,
    input  logic at_last,
    output logic start,
    output logic run,
    output logic busy
);

    play_state_e state_q;
    play_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE_TO_PLAY on an enabled trigger, PLAY_TO_IDLE on the last step.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en && trig)            state_d = ST_PLAY;
            ST_PLAY: if (en && step && at_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        start = 1'b0;
        run   = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: start = en && trig;
            ST_PLAY: begin
                run  = en;
                busy = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wave_oneshot_player.sv
module wave_oneshot_player #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter int RATE_LIMIT = 5,
    parameter int RATE_STEP  = 3,
    parameter int TBL_MUL    = 29,
    parameter int TBL_ADD    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trig,
    output logic [DW-1:0] sample,
    output logic          busy
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RW = $clog2(2 * RATE_LIMIT);

    logic          start;
    logic          run;
    logic          step;
    logic          at_last;
    logic          advance;
    logic [AW-1:0] addr_q;
    logic [RW-1:0] acc_q;

    assign advance = run && step;

    play_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .trig    (trig),
        .step    (step),
        .at_last (at_last),
        .start   (start),
        .run     (run),
        .busy    (busy)
    );

    rate_accum #(
        .LIMIT (RATE_LIMIT),
        .STEP  (RATE_STEP)
    ) u_rate (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .adv  (run),
        .step (step),
        .acc  (acc_q)
    );

    addr_walker #(
        .DEPTH (DEPTH)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .adv     (advance),
        .at_last (at_last),
        .addr    (addr_q)
    );

    wave_table #(
        .DW      (DW),
        .DEPTH   (DEPTH),
        .TBL_MUL (TBL_MUL),
        .TBL_ADD (TBL_ADD)
    ) u_tbl (
        .clk  (clk),
        .rst  (rst),
        .ld   (advance),
        .addr (addr_q),
        .data (sample)
    );

endmodule

// File: rtl/player_checks.sv
module player_checks #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter int RATE_LIMIT = 5,
    parameter int AW         = 4,
    parameter int RW         = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          trig,
    input logic [DW-1:0] sample,
    input logic          busy,
    input logic [AW-1:0] addr,
    input logic [RW-1:0] acc
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && sample == '0));

    a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig && en));

    a_r3_acc_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(acc) < RATE_LIMIT);

    a_r6_fall_at_last: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> $past(int'(addr) == DEPTH - 1));

    a_r6_addr_home_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> addr == '0);

    a_r8_enable_freeze: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sample) && $stable(busy) && $stable(addr)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(sample));

endmodule

bind wave_oneshot_player player_checks #(
    .DW         (DW),
    .DEPTH      (DEPTH),
    .RATE_LIMIT (RATE_LIMIT),
    .AW         (AW),
    .RW         (RW)
) u_checks (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .trig   (trig),
    .sample (sample),
    .busy   (busy),
    .addr   (addr_q),
    .acc    (acc_q)
);

// File: tb/tb_wave_oneshot_player.sv
module tb_wave_oneshot_player;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int RL    = 5;
    localparam int RS    = 3;
    localparam int TMUL  = 29;
    localparam int TADD  = 7;
    localparam int PASS_LEN = (DEPTH * RL + RS - 1) / RS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          trig = 1'b0;
    logic [DW-1:0] sample;
    logic          busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wave_oneshot_player #(
        .DW(DW), .DEPTH(DEPTH), .RATE_LIMIT(RL), .RATE_STEP(RS),
        .TBL_MUL(TMUL), .TBL_ADD(TADD)
    ) dut (
        .clk(clk), .rst(rst), .en(en), .trig(trig),
        .sample(sample), .busy(busy)
    );

    // R5: entry i = (29*i+7) mod 256
    function automatic int tbl(input int i);
        return (TMUL * i + TADD) % (1 << DW);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One pass, checked on every cycle. Enable is dropped for frz_len cycles
    // starting at enabled count frz_at; a trigger pulses at enabled count rt_at.
    task automatic run_pass(input string req, input int prev, input int frz_at,
                            input int frz_len, input int rt_at);
        int k = 0;
        int held = 0;
        int guard = 0;
        int steps;
        int exp_s;
        @(negedge clk);
        en = 1'b1; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(req, "busy after trigger (R2)", int'(busy), 1);
        chk(req, "sample before first step (R4)", int'(sample), prev);
        while (k < PASS_LEN && guard < 4 * PASS_LEN + 64) begin
            guard++;
            if (k == frz_at && held < frz_len) begin
                en = 1'b0; trig = 1'b1; held++;
            end else begin
                en = 1'b1; trig = (k == rt_at);
            end
            @(negedge clk);
            if (en) k++;
            steps = (k * RS) / RL;
            if (steps > DEPTH) steps = DEPTH;
            exp_s = (steps == 0) ? prev : tbl(steps - 1);
            chk(req, "sample during pass (R3 R4)", int'(sample), exp_s);
            chk(req, "busy during pass (R6)", int'(busy), (k < PASS_LEN) ? 1 : 0);
        end
        en = 1'b1; trig = 1'b0;
        chk(req, "pass length (R6)", k, PASS_LEN);
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b0; trig = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "sample in reset", int'(sample), 0);
        rst = 1'b0;
    endtask

    task automatic t_full_pass;
        run_pass("R3", 0, -1, 0, -1);
        chk("R6", "final sample", int'(sample), tbl(DEPTH - 1));
    endtask

    task automatic t_idle_hold;
        en = 1'b1; trig = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9", "idle sample hold", int'(sample), tbl(DEPTH - 1));
        chk("R9", "idle busy", int'(busy), 0);
    endtask

    task automatic t_retrigger;
        // second pass restarts at entry 0, trigger mid-pass ignored
        run_pass("R7", tbl(DEPTH - 1), -1, 0, 7);
    endtask

    task automatic t_enable_freeze;
        run_pass("R8", tbl(DEPTH - 1), 5, 4, -1);
    endtask

    task automatic t_trig_en_low;
        @(negedge clk);
        en = 1'b0; trig = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b1; trig = 1'b0;
        chk("R8", "trigger with enable low, busy", int'(busy), 0);
        @(negedge clk);
        chk("R8", "trigger with enable low, busy later", int'(busy), 0);
        chk("R8", "trigger with enable low, sample", int'(sample), tbl(DEPTH - 1));
    endtask

    task automatic t_reset_midpass;
        @(negedge clk);
        en = 1'b1; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4", "sample mid pass", int'(sample), tbl((10 * RS) / RL - 1));
        rst = 1'b1; trig = 1'b1;
        @(negedge clk);
        chk("R1", "busy after mid-pass reset", int'(busy), 0);
        chk("R1", "sample after mid-pass reset", int'(sample), 0);
        rst = 1'b0; trig = 1'b0;
        // fresh pass after reset starts from entry 0 with a cleared accumulator
        run_pass("R2", 0, -1, 0, -1);
    endtask

    initial begin
        t_reset();
        t_full_pass();
        t_idle_hold();
        t_retrigger();
        t_enable_freeze();
        t_trig_en_low();
        t_reset_midpass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule